// File: doc/BRIEF.md
# Reset and Port Shutdown Pin Conditioner

This block cleans up the slow, board-level control pins of a four-port power controller before the rest of the chip sees them. An active-low chip reset pin and one active-low shutdown pin per port are brought into the system clock domain through two-flop synchronizers. Each one then passes a qualification state machine. A level change is accepted only after the new level has held for a full minimum-width window. The window is a parameter, counted as system clock cycles per microsecond times a number of microseconds, so low glitches narrower than one microsecond never reach the chip. High glitches on an input that is already asserted are rejected in the same way.

The filtered chip reset is given out as a level that holds every port off. While this level is asserted, the register file downstream stays at its power-up values. The cycle in which the reset level deasserts produces a one-cycle release pulse. In that same cycle the synchronized strap level is captured, and the downstream register file loads its defaults from the captured value. A filtered shutdown pin raises the off request of its own port. The register file treats this request like the port's software reset bit. The live, synchronized strap level is also given out for the pin status readout.

Each filter has four named states. FLT_IDLE is deasserted and stable. FLT_QUAL_ASSERT counts consecutive low samples. FLT_ACTIVE is asserted and stable. FLT_QUAL_RELEASE counts consecutive high samples. The transitions are:
- FLT_IDLE goes to FLT_QUAL_ASSERT on a low sample.
- FLT_QUAL_ASSERT falls back to FLT_IDLE on a high sample. It advances to FLT_ACTIVE on the window-th consecutive low sample.
- FLT_ACTIVE goes to FLT_QUAL_RELEASE on a high sample.
- FLT_QUAL_RELEASE returns to FLT_ACTIVE on a low sample. It advances to FLT_IDLE on the window-th consecutive high sample.

At power-on the chip reset filter starts in FLT_ACTIVE, and the shutdown filters start in FLT_IDLE.

Top module: `pwr_pin_cond`

## Requirements
- R1: While `por_n` is low and right after it rises, `chip_rst` is 1 and every bit of `port_off_req` is 1.
- R2: When `rst_pin_n` goes low and stays low for at least Q = CYC_PER_US*MIN_PULSE_US cycles, `chip_rst` rises after the (Q+2)-th rising clock edge and not before. It then holds every `port_off_req` bit at 1.
- R3: A low pulse on `rst_pin_n` lasting Q-1 cycles or less never asserts `chip_rst`.
- R4: After `rst_pin_n` returns high, `chip_rst` falls after the (Q+2)-th rising edge and not before. A high pulse of Q-1 cycles or less while the reset is asserted is ignored.
- R5: `rst_release` is 1 for exactly the one cycle after `chip_rst` falls, and is 0 at all other times.
- R6: `auto_dflt` takes the synchronized `auto_pin` level in the cycle in which `rst_release` is 1. It keeps that value until the next release, whatever `auto_pin` does in between.
- R7: `auto_live` follows `auto_pin` two rising edges later.
- R8: A low on `shdn_pin_n[i]` that lasts at least Q cycles sets only `port_off_req[i]`, after the (Q+2)-th rising edge. The other ports stay 0.
- R9: A low pulse of Q-1 cycles or less on a shutdown pin leaves its `port_off_req` bit at 0.
- R10: After a shutdown pin returns high, its `port_off_req` bit clears after the (Q+2)-th rising edge and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset of the conditioner, active low |
| rst_pin_n | input | 1 | Raw chip reset pin, active low |
| shdn_pin_n | input | N_PORTS | Raw per-port shutdown pins, active low |
| auto_pin | input | 1 | Raw strap pin that selects the register defaults |
| chip_rst | output | 1 | Filtered chip reset level, active high |
| rst_release | output | 1 | One-cycle pulse when the filtered reset deasserts |
| port_off_req | output | N_PORTS | Per-port off request (chip reset or that port's filtered shutdown) |
| auto_live | output | 1 | Synchronized live strap level |
| auto_dflt | output | 1 | Strap level captured at reset release |

## Verification
The main function is driven with low pulses of exactly Q-1 and exactly Q cycles. These two widths separate the rejection boundary from the acceptance boundary, and any off-by-one error in the counter shows up here. Long holds are then checked at the edge just before and the edge just after the expected change, which pins down the latency of the synchronizer and the filter. High glitches during an asserted reset show whether the release path is filtered too. Each shutdown pin is exercised alone so that a crossed lane is caught, and the strap is toggled around a release so that a capture in the wrong cycle is caught.

// File: rtl/pcond_pkg.sv
package pcond_pkg;

    typedef enum logic [1:0] {
        FLT_IDLE         = 2'd0,
        FLT_QUAL_ASSERT  = 2'd1,
        FLT_ACTIVE       = 2'd2,
        FLT_QUAL_RELEASE = 2'd3
    } flt_state_e;

endpackage

// File: rtl/pcond_sync.sv
module pcond_sync #(
    parameter int W       = 1,
    parameter bit RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            stage1 <= {W{RST_VAL}};
            stage2 <= {W{RST_VAL}};
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/pcond_glitch_filter.sv
module pcond_glitch_filter
    import pcond_pkg::*;
#(
    parameter int QUAL_CYC       = 100,
    parameter bit START_ASSERTED = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic in_low,
    output logic asserted
);
    localparam int CW = $clog2(QUAL_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);
    localparam flt_state_e RST_ST = START_ASSERTED ? FLT_ACTIVE : FLT_IDLE;

    flt_state_e    state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // next-state and counter logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            FLT_IDLE: begin
                if (in_low) begin
                    state_nx = FLT_QUAL_ASSERT;
                    cnt_nx   = CW'(1);
                end
            end
            FLT_QUAL_ASSERT: begin
                if (!in_low) begin
                    state_nx = FLT_IDLE;
                    cnt_nx   = '0;
                end else if (cnt == LAST) begin
                    state_nx = FLT_ACTIVE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + CW'(1);
                end
            end
            FLT_ACTIVE: begin
                if (!in_low) begin
                    state_nx = FLT_QUAL_RELEASE;
                    cnt_nx   = CW'(1);
                end
            end
            FLT_QUAL_RELEASE: begin
                if (in_low) begin
                    state_nx = FLT_ACTIVE;
                    cnt_nx   = '0;
                end else if (cnt == LAST) begin
                    state_nx = FLT_IDLE;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt + CW'(1);
                end
            end
            default: begin
                state_nx = RST_ST;
                cnt_nx   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= RST_ST;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // outputs (Moore)
    always_comb begin
        unique case (state)
            FLT_ACTIVE, FLT_QUAL_RELEASE: asserted = 1'b1;
            default:                      asserted = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcond_strap_capture.sv
module pcond_strap_capture (
    input  logic clk,
    input  logic por_n,
    input  logic rst_level,
    input  logic auto_s,
    output logic release_pulse,
    output logic auto_dflt
);
    logic rst_prev;

    assign release_pulse = rst_prev & ~rst_level;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rst_prev  <= 1'b1;
            auto_dflt <= 1'b0;
        end else begin
            rst_prev <= rst_level;
            if (release_pulse) begin
                auto_dflt <= auto_s;
            end
        end
    end
endmodule

// File: rtl/pwr_pin_cond.sv
module pwr_pin_cond #(
    parameter int CYC_PER_US   = 100,
    parameter int MIN_PULSE_US = 1,
    parameter int N_PORTS      = 4
) (
    input  logic               clk,
    input  logic               por_n,
    input  logic               rst_pin_n,
    input  logic [N_PORTS-1:0] shdn_pin_n,
    input  logic               auto_pin,
    output logic               chip_rst,
    output logic               rst_release,
    output logic [N_PORTS-1:0] port_off_req,
    output logic               auto_live,
    output logic               auto_dflt
);
    localparam int QUAL_CYC = CYC_PER_US * MIN_PULSE_US;
    localparam int NLO      = N_PORTS + 1;

    logic [NLO-1:0]     lo_pins_s;
    logic               auto_s;
    logic [N_PORTS-1:0] shdn_f;

    pcond_sync #(.W(NLO), .RST_VAL(1'b1)) u_sync_lo (
        .clk(clk), .por_n(por_n),
        .d({rst_pin_n, shdn_pin_n}), .q(lo_pins_s)
    );

    pcond_sync #(.W(1), .RST_VAL(1'b0)) u_sync_auto (
        .clk(clk), .por_n(por_n), .d(auto_pin), .q(auto_s)
    );

    pcond_glitch_filter #(.QUAL_CYC(QUAL_CYC), .START_ASSERTED(1'b1)) u_rst_flt (
        .clk(clk), .por_n(por_n),
        .in_low(~lo_pins_s[N_PORTS]), .asserted(chip_rst)
    );

    for (genvar i = 0; i < N_PORTS; i++) begin : g_port
        pcond_glitch_filter #(.QUAL_CYC(QUAL_CYC), .START_ASSERTED(1'b0)) u_shdn_flt (
            .clk(clk), .por_n(por_n),
            .in_low(~lo_pins_s[i]), .asserted(shdn_f[i])
        );
        assign port_off_req[i] = chip_rst | shdn_f[i];
    end

    pcond_strap_capture u_strap (
        .clk(clk), .por_n(por_n), .rst_level(chip_rst), .auto_s(auto_s),
        .release_pulse(rst_release), .auto_dflt(auto_dflt)
    );

    assign auto_live = auto_s;
endmodule

// File: rtl/pwr_pin_cond_chk.sv
module pwr_pin_cond_chk #(
    parameter int N_PORTS = 4
) (
    input logic               clk,
    input logic               por_n,
    input logic               chip_rst,
    input logic               rst_release,
    input logic [N_PORTS-1:0] port_off_req,
    input logic               auto_dflt
);
    // R2
    rst_holds_ports_off_chk: assert property (@(posedge clk) disable iff (!por_n)
        chip_rst |-> (&port_off_req));

    // R5
    release_single_cycle_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_release |=> !rst_release);

    // R5
    release_after_fall_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_release |-> !chip_rst);

    // R6
    dflt_held_chk: assert property (@(posedge clk) disable iff (!por_n)
        !rst_release |=> $stable(auto_dflt));

    // R4
    no_release_while_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
        chip_rst |-> !rst_release);
endmodule

bind pwr_pin_cond pwr_pin_cond_chk #(.N_PORTS(N_PORTS)) u_chk (
    .clk(clk), .por_n(por_n), .chip_rst(chip_rst), .rst_release(rst_release),
    .port_off_req(port_off_req), .auto_dflt(auto_dflt)
);

// File: tb/pwr_pin_cond_test.sv
module pwr_pin_cond_test;
    localparam int CPU = 8;
    localparam int NP  = 4;
    localparam int Q   = CPU;

    logic          clk = 1'b0;
    logic          por_n;
    logic          rst_pin_n;
    logic [NP-1:0] shdn_pin_n;
    logic          auto_pin;
    logic          chip_rst, rst_release, auto_live, auto_dflt;
    logic [NP-1:0] port_off_req;

    int nvec = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    pwr_pin_cond #(.CYC_PER_US(CPU), .MIN_PULSE_US(1), .N_PORTS(NP)) uut (
        .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .shdn_pin_n(shdn_pin_n),
        .auto_pin(auto_pin), .chip_rst(chip_rst), .rst_release(rst_release),
        .port_off_req(port_off_req), .auto_live(auto_live), .auto_dflt(auto_dflt)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_power_on();
        por_n = 1'b0; rst_pin_n = 1'b1; shdn_pin_n = '1; auto_pin = 1'b1;
        tick(3);
        chk("R1 chip_rst in por", chip_rst, 1);
        chk("R1 port_off in por", port_off_req, 4'hF);
        por_n = 1'b1;
        @(negedge clk);
        chk("R1 chip_rst after por", chip_rst, 1);
        chk("R1 port_off after por", port_off_req, 4'hF);
        for (int i = 0; i < 4 * Q && chip_rst; i++) tick(1);
        chk("R5 release after power-on", rst_release, 1);
        tick(1);
        chk("R6 dflt from strap 1", auto_dflt, 1);
        chk("R5 release one cycle", rst_release, 0);
    endtask

    task automatic t_rst_glitch();
        int seen = 0;
        rst_pin_n = 1'b0;
        tick(Q - 1);
        rst_pin_n = 1'b1;
        for (int i = 0; i < 3 * Q; i++) begin
            if (chip_rst) seen = 1;
            tick(1);
        end
        chk("R3 short reset ignored", seen, 0);
        chk("R3 ports stay on", port_off_req, 0);
    endtask

    task automatic t_rst_assert_release();
        int seen = 0;
        rst_pin_n = 1'b0;
        tick(Q + 1);
        chk("R2 not yet asserted", chip_rst, 0);
        tick(1);
        chk("R2 asserted on time", chip_rst, 1);
        chk("R2 ports held off", port_off_req, 4'hF);
        rst_pin_n = 1'b1;
        tick(Q - 1);
        rst_pin_n = 1'b0;
        for (int i = 0; i < 2 * Q; i++) begin
            if (!chip_rst) seen = 1;
            tick(1);
        end
        chk("R4 high glitch ignored", seen, 0);
        auto_pin = 1'b0;
        rst_pin_n = 1'b1;
        tick(Q + 1);
        chk("R4 not yet released", chip_rst, 1);
        chk("R5 no early release", rst_release, 0);
        tick(1);
        chk("R4 released on time", chip_rst, 0);
        chk("R5 release pulse", rst_release, 1);
        tick(1);
        chk("R5 pulse ends", rst_release, 0);
        chk("R6 dflt from strap 0", auto_dflt, 0);
        auto_pin = 1'b1;
        tick(5);
        chk("R6 dflt held", auto_dflt, 0);
    endtask

    task automatic t_auto_live();
        auto_pin = 1'b0;
        tick(4);
        auto_pin = 1'b1;
        tick(1);
        chk("R7 live not yet", auto_live, 0);
        tick(1);
        chk("R7 live follows", auto_live, 1);
    endtask

    task automatic t_shdn(input int p);
        int seen = 0;
        shdn_pin_n[p] = 1'b0;
        tick(Q - 1);
        shdn_pin_n[p] = 1'b1;
        for (int i = 0; i < 3 * Q; i++) begin
            if (port_off_req != 0) seen = 1;
            tick(1);
        end
        chk("R9 shutdown glitch ignored", seen, 0);
        shdn_pin_n[p] = 1'b0;
        tick(Q + 1);
        chk("R8 not yet off", port_off_req, 0);
        tick(1);
        chk("R8 only this port off", port_off_req, 1 << p);
        shdn_pin_n[p] = 1'b1;
        tick(Q + 1);
        chk("R10 still off", port_off_req, 1 << p);
        tick(1);
        chk("R10 released", port_off_req, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        t_power_on();
        t_rst_glitch();
        t_rst_assert_release();
        t_auto_live();
        for (int p = 0; p < NP; p++) t_shdn(p);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule